// File: doc/BRIEF.md
# Accumulator ALU with Carry/Borrow Flag

This block holds an 8-bit accumulator and a 1-bit carry/borrow flag and updates both from a memory operand byte when a strobe is raised. A 4-bit operation code selects between a plain load, three bitwise operations, add with and without carry-in, subtraction in both directions (operand minus accumulator, and accumulator minus operand) with and without an incoming borrow, and four single-bit shifts. Two of the shifts fill with zero. The other two rotate through the flag.

The surrounding datapath fetches the operand byte, presents it on `mem_byte` together with the operation code, and pulses `op_valid` for one clock. The new accumulator and flag appear on the outputs after that rising edge. Subtraction uses the "no borrow" convention: the flag reads 1 when the result did not go negative. Only arithmetic and shift operations can change the flag.

The reset input is asserted asynchronously. Its release is synchronised inside the block, so strobes in the first two clocks after `rst_n` rises are not acted on.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, the accumulator reads 0x00 and the flag reads 0.
- R2: When `op_valid` is low at a rising edge, the accumulator and flag keep their values, whatever `op_sel` and `mem_byte` carry.
- R3: Codes 0x0 (load operand), 0x1 (OR), 0x2 (AND) and 0x3 (XOR) write the result of operand with accumulator into the accumulator and leave the flag unchanged.
- R4: Code 0x4 computes operand + accumulator. The low 8 bits go to the accumulator and the carry out goes to the flag.
- R5: Code 0x5 computes operand + accumulator + flag. The low 8 bits go to the accumulator and the carry out goes to the flag.
- R6: Code 0x6 computes operand − accumulator as an 8-bit two's complement result. The flag becomes 1 when operand ≥ accumulator (no borrow) and 0 otherwise.
- R7: Code 0x7 computes operand − accumulator − (1 − flag). The flag becomes 1 exactly when no borrow occurred.
- R8: Code 0x8 computes accumulator − operand, and code 0x9 computes accumulator − operand − (1 − flag). In both cases the flag becomes 1 exactly when no borrow occurred.
- R9: Code 0xA shifts the accumulator right, with bit 0 going to the flag and 0 entering bit 7. Code 0xB shifts it left, with bit 7 going to the flag and 0 entering bit 0. The old flag value is not used.
- R10: Code 0xC rotates right through the flag: bit 0 goes to the flag and the old flag enters bit 7. Code 0xD rotates left: bit 7 goes to the flag and the old flag enters bit 0.
- R11: Codes 0xE and 0xF, when strobed, leave the accumulator and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| op_valid | input | 1 | Update strobe for accumulator and flag |
| op_sel | input | 4 | Operation code |
| mem_byte | input | 8 | Memory operand byte |
| acc_out | output | 8 | Accumulator value |
| flag_out | output | 1 | Carry / no-borrow flag |

## Verification
The bench targets the points where carry and borrow conventions are easy to invert.

- **Equal operands in subtraction.** These must give 0x00 with the flag set. A design that treated the flag as "borrow" would clear it.
- **Borrow-in with a cleared flag.** Subtracting equal values must give 0xFF with the flag clear. A design that fed the flag straight in as a borrow would be off by one.
- **Subtraction direction.** Both directions are driven with the same values. Swapped operands show up as a negated result.
- **Shifts with the flag already set.** A zero-fill shift that leaked the flag would put a 1 in the vacated bit.
- **Rotates.** Each rotate must carry the old flag into the opposite end.
- **Logic and load after a carry.** These must preserve the flag, so a design that cleared it on every strobe is caught.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'h0,
    OP_OR    = 4'h1,
    OP_AND   = 4'h2,
    OP_XOR   = 4'h3,
    OP_ADD   = 4'h4,
    OP_ADDC  = 4'h5,
    OP_RSUB  = 4'h6,
    OP_RSUBB = 4'h7,
    OP_SUB   = 4'h8,
    OP_SUBB  = 4'h9,
    OP_SHR   = 4'hA,
    OP_SHL   = 4'hB,
    OP_ROR   = 4'hC,
    OP_ROL   = 4'hD,
    OP_RSV0  = 4'hE,
    OP_RSV1  = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_LOGIC,
    CLS_ARITH,
    CLS_SHIFT,
    CLS_NONE
  } op_class_e;

  function automatic op_class_e classify(input logic [3:0] op);
    op_class_e c;
    case (op)
      OP_LOAD, OP_OR, OP_AND, OP_XOR:                   c = CLS_LOGIC;
      OP_ADD, OP_ADDC, OP_RSUB, OP_RSUBB, OP_SUB, OP_SUBB: c = CLS_ARITH;
      OP_SHR, OP_SHL, OP_ROR, OP_ROL:                   c = CLS_SHIFT;
      default:                                          c = CLS_NONE;
    endcase
    return c;
  endfunction

  function automatic logic is_subtract(input logic [3:0] op);
    return (op == OP_RSUB) || (op == OP_RSUBB) || (op == OP_SUB) || (op == OP_SUBB);
  endfunction

endpackage

// File: rtl/acc_alu_rst_sync.sv
module acc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [1:0]   fn,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] y
);

  always_comb begin
    case (fn)
      2'd0:    y = opnd;
      2'd1:    y = opnd | acc;
      2'd2:    y = opnd & acc;
      default: y = opnd ^ acc;
    endcase
  end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic         flag_in,
  input  logic         subtract,
  input  logic         acc_minus,
  input  logic         use_flag,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int SW = W + 1;

  logic [W-1:0]  lhs, rhs, rhs_eff;
  logic          cin;
  logic [SW-1:0] total;

  always_comb begin
    lhs     = acc_minus ? acc : opnd;
    rhs     = acc_minus ? opnd : acc;
    rhs_eff = subtract ? ~rhs : rhs;
    // a - b - !f == a + ~b + f ; a - b == a + ~b + 1
    cin     = use_flag ? flag_in : subtract;
    total   = {1'b0, lhs} + {1'b0, rhs_eff} + {{(SW-1){1'b0}}, cin};
  end

  assign sum  = total[W-1:0];
  assign cout = total[SW-1];

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic         flag_in,
  input  logic         left,
  input  logic         ring,
  output logic [W-1:0] y,
  output logic         fout
);

  logic fill;

  always_comb begin
    fill = ring ? flag_in : 1'b0;
    if (left) begin
      y    = {acc[W-2:0], fill};
      fout = acc[W-1];
    end else begin
      y    = {fill, acc[W-1:1]};
      fout = acc[0];
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] mem_byte,
  output logic [W-1:0] acc_out,
  output logic         flag_out
);

  logic         core_rst_n;
  logic [W-1:0] acc_q, acc_d;
  logic         flag_q, flag_d;
  logic         upd_en;
  op_class_e    cls;

  logic [W-1:0] logic_y, arith_y, shift_y;
  logic         arith_c, shift_c;

  acc_alu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  assign cls    = classify(op_sel);
  assign upd_en = op_valid;

  acc_alu_logic #(.W(W)) u_logic (
    .fn   (op_sel[1:0]),
    .acc  (acc_q),
    .opnd (mem_byte),
    .y    (logic_y)
  );

  acc_alu_arith #(.W(W)) u_arith (
    .acc       (acc_q),
    .opnd      (mem_byte),
    .flag_in   (flag_q),
    .subtract  (is_subtract(op_sel)),
    .acc_minus (op_sel[3]),
    .use_flag  (op_sel[0]),
    .sum       (arith_y),
    .cout      (arith_c)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .acc     (acc_q),
    .flag_in (flag_q),
    .left    (op_sel[0]),
    .ring    (op_sel[2]),
    .y       (shift_y),
    .fout    (shift_c)
  );

  always_comb begin
    acc_d  = acc_q;
    flag_d = flag_q;
    case (cls)
      CLS_LOGIC: acc_d = logic_y;
      CLS_ARITH: begin
        acc_d  = arith_y;
        flag_d = arith_c;
      end
      CLS_SHIFT: begin
        acc_d  = shift_y;
        flag_d = shift_c;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd_en) begin
      acc_q  <= acc_d;
      flag_q <= flag_d;
    end
  end

  assign acc_out  = acc_q;
  assign flag_out = flag_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         core_rst_n,
  input logic         op_valid,
  input logic [3:0]   op_sel,
  input logic [W-1:0] mem_byte,
  input logic [W-1:0] acc_out,
  input logic         flag_out
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (acc_out == '0 && flag_out == 1'b0);
    end
  end

  a_r2_hold_no_strobe: assert property (@(posedge clk) disable iff (!core_rst_n)
    !op_valid |=> ($stable(acc_out) && $stable(flag_out)));

  a_r3_logic_keeps_flag: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_valid && op_sel[3:2] == 2'b00) |=> $stable(flag_out));

  a_r3_load_value: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_valid && op_sel == OP_LOAD) |=> (acc_out == $past(mem_byte)));

  a_r4_add_sum: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_valid && op_sel == OP_ADD) |=>
      ({flag_out, acc_out} == ({1'b0, $past(mem_byte)} + {1'b0, $past(acc_out)})));

  a_r6_rsub_noborrow: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_valid && op_sel == OP_RSUB) |=>
      ((flag_out == ($past(mem_byte) >= $past(acc_out))) &&
       (acc_out == W'($past(mem_byte) - $past(acc_out)))));

  a_r9_shr_zero_fill: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_valid && op_sel == OP_SHR) |=>
      ((flag_out == $past(acc_out[0])) && (acc_out == ($past(acc_out) >> 1))));

  a_r10_ror_through_flag: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_valid && op_sel == OP_ROR) |=>
      ((flag_out == $past(acc_out[0])) && (acc_out == {$past(flag_out), $past(acc_out[W-1:1])})));

  a_r11_reserved_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    (op_valid && op_sel[3:1] == 3'b111) |=> ($stable(acc_out) && $stable(flag_out)));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .op_valid   (op_valid),
  .op_sel     (op_sel),
  .mem_byte   (mem_byte),
  .acc_out    (acc_out),
  .flag_out   (flag_out)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_sel;
  logic [7:0] mem_byte;
  logic [7:0] acc_out;
  logic       flag_out;

  int n_vec;
  int n_bad;
  bit done;

  acc_alu uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .mem_byte (mem_byte),
    .acc_out  (acc_out),
    .flag_out (flag_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] ed, input logic edf);
    n_vec++;
    if (acc_out !== ed || flag_out !== edf) begin
      n_bad++;
      $display("FAIL %s: got D=%h DF=%b, expected D=%h DF=%b", tag, acc_out, flag_out, ed, edf);
    end
  endtask

  // one strobed operation; outputs sampled at the following falling edge
  task automatic do_op(input logic [3:0] op, input logic [7:0] m);
    @(negedge clk);
    op_valid = 1'b1;
    op_sel   = op;
    mem_byte = m;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // flag via shift-left of 0x80 or 0x00, then load keeps it
  task automatic set_state(input logic [7:0] d, input logic df);
    do_op(4'h0, df ? 8'h80 : 8'h00);
    do_op(4'hB, 8'h00);
    do_op(4'h0, d);
  endtask

  task automatic t_reset;
    rst_n    = 1'b1;
    op_valid = 1'b0;
    op_sel   = 4'h0;
    mem_byte = 8'h00;
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_logic;
    set_state(8'h00, 1'b1);
    do_op(4'h0, 8'h5A); check("R3 load", 8'h5A, 1'b1);
    do_op(4'h1, 8'h0F); check("R3 or",   8'h5F, 1'b1);
    do_op(4'h2, 8'hF0); check("R3 and",  8'h50, 1'b1);
    do_op(4'h3, 8'hFF); check("R3 xor",  8'hAF, 1'b1);
    set_state(8'h0F, 1'b0);
    do_op(4'h3, 8'hFF); check("R3 xor df0", 8'hF0, 1'b0);
  endtask

  task automatic t_add;
    set_state(8'h7F, 1'b0); do_op(4'h4, 8'h01); check("R4", 8'h80, 1'b0);
    set_state(8'hFF, 1'b0); do_op(4'h4, 8'h01); check("R4 carry", 8'h00, 1'b1);
    set_state(8'hFF, 1'b1); do_op(4'h5, 8'h00); check("R5 carry", 8'h00, 1'b1);
    set_state(8'h10, 1'b1); do_op(4'h5, 8'h20); check("R5 cin1", 8'h31, 1'b0);
    set_state(8'h10, 1'b0); do_op(4'h5, 8'h20); check("R5 cin0", 8'h30, 1'b0);
  endtask

  task automatic t_sub;
    set_state(8'h05, 1'b0); do_op(4'h6, 8'h08); check("R6", 8'h03, 1'b1);
    set_state(8'h08, 1'b1); do_op(4'h6, 8'h05); check("R6 borrow", 8'hFD, 1'b0);
    set_state(8'h33, 1'b0); do_op(4'h6, 8'h33); check("R6 equal", 8'h00, 1'b1);
    set_state(8'h05, 1'b0); do_op(4'h7, 8'h08); check("R7", 8'h02, 1'b1);
    set_state(8'h05, 1'b0); do_op(4'h7, 8'h05); check("R7 borrow", 8'hFF, 1'b0);
    set_state(8'h05, 1'b1); do_op(4'h7, 8'h05); check("R7 noborrow", 8'h00, 1'b1);
    set_state(8'h08, 1'b0); do_op(4'h8, 8'h05); check("R8 sub", 8'h03, 1'b1);
    set_state(8'h05, 1'b1); do_op(4'h8, 8'h08); check("R8 sub borrow", 8'hFD, 1'b0);
    set_state(8'h08, 1'b0); do_op(4'h9, 8'h05); check("R8 subb", 8'h02, 1'b1);
    set_state(8'h00, 1'b0); do_op(4'h9, 8'h00); check("R8 subb borrow", 8'hFF, 1'b0);
  endtask

  task automatic t_shift;
    set_state(8'h81, 1'b0); do_op(4'hA, 8'h00); check("R9 shr", 8'h40, 1'b1);
    do_op(4'hA, 8'h00); check("R9 shr again", 8'h20, 1'b0);
    set_state(8'h81, 1'b1); do_op(4'hA, 8'hFF); check("R9 shr fill0", 8'h40, 1'b1);
    set_state(8'h81, 1'b1); do_op(4'hB, 8'hFF); check("R9 shl", 8'h02, 1'b1);
    set_state(8'h40, 1'b1); do_op(4'hB, 8'h00); check("R9 shl fill0", 8'h80, 1'b0);
  endtask

  task automatic t_rotate;
    set_state(8'h02, 1'b1); do_op(4'hC, 8'h00); check("R10 ror", 8'h81, 1'b0);
    set_state(8'h01, 1'b0); do_op(4'hC, 8'h00); check("R10 ror out", 8'h00, 1'b1);
    set_state(8'h80, 1'b1); do_op(4'hD, 8'h00); check("R10 rol", 8'h01, 1'b1);
    set_state(8'h40, 1'b1); do_op(4'hD, 8'h00); check("R10 rol in", 8'h81, 1'b0);
  endtask

  task automatic t_hold;
    set_state(8'h3C, 1'b1);
    @(negedge clk);
    op_valid = 1'b0;
    op_sel   = 4'h4;
    mem_byte = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2", 8'h3C, 1'b1);
    end
  endtask

  task automatic t_unused;
    set_state(8'h3C, 1'b1);
    do_op(4'hE, 8'hFF); check("R11 code E", 8'h3C, 1'b1);
    do_op(4'hF, 8'h00); check("R11 code F", 8'h3C, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    t_reset;
    t_logic;
    t_add;
    t_sub;
    t_shift;
    t_rotate;
    t_hold;
    t_unused;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run;
  end

endmodule